// File: doc/BRIEF.md
# SPI Slave Memory Access Port

This block lets an external SPI host reach a 16-bit-addressed byte memory space and post requests to a local processor. The host frames each transfer with an active-low chip select. It sends, most significant bit first, a command byte, then a 16-bit address, then any number of data bytes. The two top command bits choose the transfer type. `11` reads: bytes are shifted out from the address upward. `10` writes: each received byte is stored from the address upward. Any code with the top bit clear is a request to the processor. For such a request, the command and address are latched and the data bytes are dropped.

All SPI pins are oversampled in the system clock domain. A memory request is a single-cycle strobe. Read data is expected one system clock after a read strobe. When chip select rises after a frame, the processor gets a one-clock interrupt pulse. There are two exceptions: the plain read code 0xC0 and the plain write code 0x80 stay silent. The last command and the last complete address stay visible on two output registers. While chip select is high, the serial data output is released, and clock and data-in activity do nothing.

Top module: `spi_mem_port`

## Requirements
- R1: While chip select is high, `miso_oe` is 0, and toggling `sclk`/`mosi` produces no memory strobe and no interrupt.
- R2: In a frame, the first 8 bits (MSB first) form the command and the next 16 bits form the address. `last_cmd` takes the command once its 8th bit arrives. `last_addr` takes the address once its 16th bit arrives. A frame that ends early leaves the unreceived register unchanged.
- R3: A command with bits [7:6] = 2'b11 is a read. From bit 24 on, `miso` carries the byte at the address, then the byte at address+1, and so on, MSB first. While chip select is low and no read data is being shifted, `miso` is 0.
- R4: A command with bits [7:6] = 2'b10 is a write. Each complete received data byte is written with one `mem_we` strobe to the address, then address+1, and so on. A trailing partial byte is not written.
- R5: The auto-incremented address wraps from 0xFFFF to 0x0000.
- R6: Read code 0xC0 and write code 0x80 raise no interrupt. Every other read or write code raises one.
- R7: A command with bit 7 = 0 is processor-only. It produces no memory write, its data bytes are ignored, and it raises the interrupt.
- R8: `irq` is a single-clock pulse issued after chip select rises. It is issued only if a full command byte was received and R6 does not suppress it.
- R9: After reset, `irq`, `mem_we`, `mem_re` and `miso_oe` are 0, and `last_cmd` and `last_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idle low, data sampled on rising edge |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host (valid while `miso_oe` is 1) |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| mem_addr | output | 16 | Byte address of the current memory strobe |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-clock write strobe |
| mem_re | output | 1 | One-clock read strobe |
| mem_rdata | input | 8 | Read data, valid one clock after `mem_re` |
| irq | output | 1 | One-clock processor interrupt pulse |
| last_cmd | output | 8 | Last command byte received |
| last_addr | output | 16 | Last complete address received |

## Verification
Every SPI input passes a two-flop synchronizer and an edge register. Because of this, `miso_oe` follows chip select two clocks later, a memory strobe comes three clocks after an `sclk` rise, and `irq` comes three clocks after chip select rises. The bench records chip select on each clock and compares `miso_oe` against the value two edges back on every falling clock edge. It also flags any `irq` longer than one clock. The host task samples `miso` just before each rising `sclk`, at least eight clocks after the design updated it. Write addresses, write data and interrupt counts are logged as they happen and compared once the frame has settled, ten clocks after chip select rises.

// File: rtl/spi_mem_pkg.sv
// Shared types for the SPI memory access port.
// Assumes: command bits [7:6] carry the transfer type.
package spi_mem_pkg;

    typedef enum logic [1:0] {
        KIND_CTRL  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_READ  = 2'd2
    } xfer_kind_t;

    // Map a command byte to its transfer type
    function automatic xfer_kind_t kind_of(input logic [7:0] cmd);
        if (!cmd[7])     return KIND_CTRL;
        else if (cmd[6]) return KIND_READ;
        else             return KIND_WRITE;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchronizer for a small bus of asynchronous inputs.
// Assumes: each bit is independent; the reset value sets the idle level.
module spi_in_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
// Frame engine: edge detect, shift, command decode, memory strobes,
// auto-increment, read data shifting and interrupt generation.
// Assumes: synchronized inputs; half sclk period >= 4 system clocks;
// memory returns read data one clock after mem_re.
module spi_frame_engine
    import spi_mem_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [7:0]  QUIET_RD = 8'hC0,
    parameter logic [7:0]  QUIET_WR = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              irq,
    output logic [7:0]        last_cmd,
    output logic [ADDR_W-1:0] last_addr,
    output logic              miso,
    output logic              miso_oe
);
    localparam int HDR_BITS = 8 + ADDR_W;
    localparam int CNT_W    = $clog2(HDR_BITS + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_DONE  = CNT_W'(HDR_BITS);

    logic              cs_q, sclk_q, rise, cs_rise;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [2:0]        bidx;
    logic [ADDR_W-2:0] sh;
    logic [ADDR_W-1:0] nb, cur_addr;
    logic              cmd_ok, re_d, quiet;
    xfer_kind_t        kind;
    logic [7:0]        tx_byte;

    assign rise    = !cs_s && sclk_s && !sclk_q;
    assign cs_rise = cs_s && !cs_q;
    assign nb      = {sh, mosi_s};
    assign quiet   = (kind == KIND_READ  && last_cmd == QUIET_RD) ||
                     (kind == KIND_WRITE && last_cmd == QUIET_WR);

    // Edge-detect history of chip select and serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    // Frame sequencing, memory strobes and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_cnt   <= '0;
            bidx      <= '0;
            sh        <= '0;
            cmd_ok    <= 1'b0;
            kind      <= KIND_CTRL;
            cur_addr  <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            re_d      <= 1'b0;
            tx_byte   <= '0;
            irq       <= 1'b0;
            last_cmd  <= '0;
            last_addr <= '0;
        end else begin
            mem_we <= 1'b0;
            mem_re <= 1'b0;
            re_d   <= mem_re;
            irq    <= cs_rise && cmd_ok && !quiet;
            if (re_d) tx_byte <= mem_rdata;
            if (cs_s) begin
                hdr_cnt <= '0;
                bidx    <= '0;
                cmd_ok  <= 1'b0;
            end else if (rise) begin
                sh <= nb[ADDR_W-2:0];
                if (hdr_cnt != HDR_DONE) begin
                    hdr_cnt <= hdr_cnt + 1'b1;
                    if (hdr_cnt == CMD_LAST) begin
                        last_cmd <= nb[7:0];
                        kind     <= kind_of(nb[7:0]);
                        cmd_ok   <= 1'b1;
                    end
                    if (hdr_cnt == ADDR_LAST) begin
                        last_addr <= nb;
                        if (kind == KIND_READ) begin
                            mem_re   <= 1'b1;
                            mem_addr <= nb;
                            cur_addr <= nb + 1'b1;
                        end else begin
                            cur_addr <= nb;
                        end
                    end
                end else begin
                    bidx <= bidx + 1'b1;
                    if (bidx == 3'd7 && kind == KIND_WRITE) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= cur_addr;
                        mem_wdata <= nb[7:0];
                        cur_addr  <= cur_addr + 1'b1;
                    end
                    if (bidx == 3'd7 && kind == KIND_READ) begin
                        mem_re   <= 1'b1;
                        mem_addr <= cur_addr;
                        cur_addr <= cur_addr + 1'b1;
                    end
                end
            end
        end
    end

    // Output driver: data only during the read data phase
    always_comb begin
        miso_oe = !cs_s;
        miso    = 1'b0;
        if (!cs_s && kind == KIND_READ && hdr_cnt == HDR_DONE)
            miso = tx_byte[3'd7 - bidx];
    end

    // R8: interrupt is a single-clock pulse
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: interrupt only once the frame has ended
    p_irq_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cs_s);
    // R1: no memory strobe while the port is deselected
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> (!mem_we && !mem_re));
    // R4: writes only for write frames, never with a read strobe
    p_we_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (kind == KIND_WRITE && !mem_re));
    // R3: read strobes only for read frames
    p_re_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (kind == KIND_READ));
    // R2: command register changes only with a completed command byte
    p_cmd_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_cmd) |-> cmd_ok);
endmodule

// File: rtl/spi_mem_port.sv
// SPI slave memory access port top: synchronizes the pad inputs and
// hands them to the frame engine.
// Assumes: pad driver releases miso when miso_oe is low.
module spi_mem_port #(
    parameter int         ADDR_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] QUIET_RD    = 8'hC0,
    parameter logic [7:0] QUIET_WR    = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              irq,
    output logic [7:0]        last_cmd,
    output logic [ADDR_W-1:0] last_addr
);
    logic [2:0] pins_s;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, mosi}),
        .q     (pins_s)
    );

    spi_frame_engine #(.ADDR_W(ADDR_W), .QUIET_RD(QUIET_RD), .QUIET_WR(QUIET_WR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .irq       (irq),
        .last_cmd  (last_cmd),
        .last_addr (last_addr),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );
endmodule

// File: tb/spi_mem_port_tb.sv
module spi_mem_port_tb;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, mem_we, mem_re, irq;
    logic [15:0] mem_addr, last_addr;
    logic [7:0]  mem_wdata, mem_rdata, last_cmd;

    int checks = 0, fails = 0, irq_cnt = 0, cyc = 0;
    bit done = 0;
    logic h0 = 1'b1, h1 = 1'b1, irq_prev = 1'b0;
    logic [7:0] bmem [256];
    logic [7:0] txb [16];
    logic [7:0] rxb [16];
    int wq_a[$];
    int wq_d[$];

    always #4 clk = ~clk;

    spi_mem_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .irq(irq),
        .last_cmd(last_cmd), .last_addr(last_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural memory model with logging, plus chip-select history
    always @(posedge clk) begin
        cyc <= cyc + 1;
        h0 <= cs_n;
        h1 <= h0;
        if (irq) irq_cnt <= irq_cnt + 1;
        if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
        if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
            wq_a.push_back(int'(mem_addr));
            wq_d.push_back(int'(mem_wdata));
        end
    end

    // Per-clock reference: oe follows chip select two edges late (R1), irq width (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(miso_oe == !h1, "R1 miso_oe vs cs", miso_oe, !h1);
            chk(!(irq && irq_prev), "R8 irq single clock", irq, 0);
        end
        irq_prev = irq;
    end

    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Host frame: nbits bits from txb, MSB first; miso captured into rxb
    task automatic spi_xfer(input int nbits);
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = txb[i/8][7 - (i%8)];
            repeat (HALF) @(negedge clk);
            rxb[i/8][7 - (i%8)] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic hdr(input logic [7:0] c, input logic [15:0] a);
        txb[0] = c; txb[1] = a[15:8]; txb[2] = a[7:0];
    endtask

    initial begin
        int ic;
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5A;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(!irq && !mem_we && !mem_re, "R9 strobes idle", {irq, mem_we, mem_re}, 0);
        chk(!miso_oe, "R9 miso_oe", miso_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(last_cmd == 0 && last_addr == 0, "R9 last regs", {last_cmd, last_addr}, 0);

        // R1: activity while deselected
        for (int i = 0; i < 40; i++) begin
            sclk = ~sclk; mosi = i[1];
            repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (10) @(negedge clk);
        chk(wq_a.size() == 0 && irq_cnt == 0, "R1 no effect", wq_a.size() + irq_cnt, 0);

        // R4/R2/R6: write 3 bytes with interrupt code
        hdr(8'h81, 16'h0010); txb[3] = 8'hA5; txb[4] = 8'h3C; txb[5] = 8'h7E;
        ic = irq_cnt; spi_xfer(48);
        chk(wq_a.size() == 3, "R4 write count", wq_a.size(), 3);
        for (int i = 0; i < 3 && i < wq_a.size(); i++) begin
            chk(wq_a[i] == 16 + i, "R4 write addr", wq_a[i], 16 + i);
            chk(wq_d[i] == int'(txb[3+i]), "R4 write data", wq_d[i], txb[3+i]);
        end
        chk(irq_cnt - ic == 1, "R6 write irq", irq_cnt - ic, 1);
        chk(last_cmd == 8'h81 && last_addr == 16'h0010, "R2 last regs", {last_cmd, last_addr}, 24'h810010);
        wq_a.delete(); wq_d.delete();

        // R3: read 3 bytes from 0x0011
        hdr(8'hC3, 16'h0011); for (int i = 3; i < 6; i++) txb[i] = 8'hFF;
        ic = irq_cnt; spi_xfer(48);
        chk(rxb[0] == 0 && rxb[1] == 0 && rxb[2] == 0, "R3 miso low in header", {rxb[0], rxb[1], rxb[2]}, 0);
        chk(rxb[3] == 8'h3C, "R3 read byte0", rxb[3], 8'h3C);
        chk(rxb[4] == 8'h7E, "R3 read byte1", rxb[4], 8'h7E);
        chk(rxb[5] == (8'h13 ^ 8'h5A), "R3 read byte2", rxb[5], 8'h13 ^ 8'h5A);
        chk(irq_cnt - ic == 1, "R6 read irq", irq_cnt - ic, 1);
        chk(wq_a.size() == 0, "R3 no write", wq_a.size(), 0);

        // R6: quiet codes
        hdr(8'h80, 16'h0040); txb[3] = 8'h11;
        ic = irq_cnt; spi_xfer(32);
        chk(wq_a.size() == 1 && wq_d[0] == 8'h11, "R6 quiet write stored", wq_a.size(), 1);
        chk(irq_cnt == ic, "R6 0x80 no irq", irq_cnt - ic, 0);
        wq_a.delete(); wq_d.delete();
        hdr(8'hC0, 16'h0040); txb[3] = 8'h00;
        ic = irq_cnt; spi_xfer(32);
        chk(rxb[3] == 8'h11, "R6 quiet read data", rxb[3], 8'h11);
        chk(irq_cnt == ic, "R6 0xC0 no irq", irq_cnt - ic, 0);

        // R5: wrap at top of address space
        hdr(8'h82, 16'hFFFF); txb[3] = 8'h22; txb[4] = 8'h33;
        spi_xfer(40);
        chk(wq_a.size() == 2, "R5 wrap count", wq_a.size(), 2);
        if (wq_a.size() == 2) begin
            chk(wq_a[0] == 16'hFFFF, "R5 first addr", wq_a[0], 16'hFFFF);
            chk(wq_a[1] == 0, "R5 wrapped addr", wq_a[1], 0);
        end
        wq_a.delete(); wq_d.delete();

        // R7: processor-only command with data bytes
        hdr(8'h35, 16'h1234); txb[3] = 8'h99;
        ic = irq_cnt; spi_xfer(32);
        chk(wq_a.size() == 0, "R7 no write", wq_a.size(), 0);
        chk(rxb[3] == 0, "R7 miso idle", rxb[3], 0);
        chk(irq_cnt - ic == 1, "R7 irq", irq_cnt - ic, 1);
        chk(last_cmd == 8'h35 && last_addr == 16'h1234, "R7 latched", {last_cmd, last_addr}, 24'h351234);

        // R2/R7: command-only frame keeps old address
        txb[0] = 8'h07;
        ic = irq_cnt; spi_xfer(8);
        chk(last_cmd == 8'h07 && last_addr == 16'h1234, "R2 cmd-only regs", {last_cmd, last_addr}, 24'h071234);
        chk(irq_cnt - ic == 1, "R7 cmd-only irq", irq_cnt - ic, 1);

        // R8: aborted before command completes
        txb[0] = 8'hC5;
        ic = irq_cnt; spi_xfer(5);
        chk(irq_cnt == ic, "R8 short frame no irq", irq_cnt - ic, 0);
        chk(last_cmd == 8'h07, "R8 last_cmd kept", last_cmd, 8'h07);

        // R4: trailing partial byte dropped
        hdr(8'h90, 16'h0050); txb[3] = 8'hF0;
        ic = irq_cnt; spi_xfer(28);
        chk(wq_a.size() == 0, "R4 partial byte", wq_a.size(), 0);
        chk(irq_cnt - ic == 1, "R8 irq after partial write", irq_cnt - ic, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule